// File: doc/BRIEF.md
# Threshold-Paced DMA Byte Buffer

This block sits between a disk-side byte stream and one host DMA channel. It buffers up to 16 bytes and drives the DMA request line so that the host is asked for service at a programmable fill level. Bytes can flow from the drive to the host (read) or from the host to the drive (write and verify). A configuration strobe loads three settings: a buffer-enable bit, a 4-bit threshold field and a burst-mode bit. With the buffer disabled, which is the reset state, it behaves as a single-byte holding register and every byte needs its own DMA cycle.

A transfer begins with a one-cycle `cmd_start` strobe, which also gives the direction. This strobe empties the buffer and clears the error flag. The drive side pushes bytes in read transfers and pops bytes in write transfers. It watches `drv_stall`, and it marks the last byte of a sector with `drv_last`. The host side completes one byte per cycle in which `dma_ack` is high while `dma_req` is high. Terminal count, given with an accepted acknowledge, ends the command.

Top module: `xfer_fifo_dma`

## Requirements
- R1: After reset, `dma_req` is 0, `fifo_empty` is 1, `xfer_err` is 0, and the buffer is disabled with an effective depth of one byte.
- R2: A cycle with `cfg_wr`=1 loads `cfg_fifo_en`, `cfg_thr` and `cfg_burst`. The effective threshold T is `cfg_thr`+1, giving a range of 1 to 16.
- R3: In read (`cmd_dir`=1), `dma_req` rises in the cycle after occupancy reaches 16−T. The level is raised to 1 when that value is 0. With the buffer disabled the level is 1.
- R4: In read, a byte pushed with `drv_last`=1 raises `dma_req` in the next cycle at any nonzero occupancy.
- R5: In read, `dma_req` stays asserted, except for single-mode gaps, until the buffer has been drained to empty. It is 0 from the cycle after the last byte leaves.
- R6: In write (`cmd_dir`=0), `dma_req` is 1 in the cycle after `cmd_start` and stays asserted until the buffer is full.
- R7: In write, after a full-buffer release, `dma_req` reasserts once occupancy has fallen to T or below. With the buffer disabled this happens once the single slot is free.
- R8: An accepted acknowledge with `dma_tc`=1 moves its byte and ends the command. `dma_req` then stays 0 until the next `cmd_start`.
- R9: With `cfg_burst`=0, `dma_req` is 0 for exactly one cycle after each accepted acknowledge and is then evaluated again.
- R10: With `cfg_burst`=1, `dma_req` stays 1 through consecutive accepted acknowledges until the stop condition.
- R11: With the buffer disabled, `fifo_full` is 1 whenever one byte is held.
- R12: `drv_stall` is high on a full buffer in read and on an empty buffer in write. A drive push to a full buffer, or a drive pop from an empty one, sets the sticky `xfer_err`, which only `cmd_start` clears.
- R13: Bytes leave in the order they entered. `head_data` always shows the oldest byte.
- R14: `dma_ack` while `dma_req` is 0 moves no byte and does not change `dma_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load configuration strobe |
| cfg_fifo_en | input | 1 | Buffer enable (0 = single-byte) |
| cfg_thr | input | 4 | Threshold field, effective T = value + 1 |
| cfg_burst | input | 1 | 1 = burst DMA, 0 = single transfer |
| cmd_start | input | 1 | Enter execution phase, flush buffer |
| cmd_dir | input | 1 | 1 = drive to host, 0 = host to drive |
| drv_push | input | 1 | Drive delivers a byte (read) |
| drv_last | input | 1 | Pushed byte ends a sector |
| drv_wdata | input | 8 | Drive byte |
| drv_pop | input | 1 | Drive takes a byte (write) |
| drv_stall | output | 1 | Drive must wait |
| dma_ack | input | 1 | DMA acknowledge |
| dma_tc | input | 1 | Terminal count, valid with acknowledge |
| dma_wdata | input | 8 | Host byte (write) |
| dma_req | output | 1 | DMA request |
| head_data | output | 8 | Oldest buffered byte |
| fifo_empty | output | 1 | Buffer holds no byte |
| fifo_full | output | 1 | Buffer holds its effective depth |
| xfer_err | output | 1 | Sticky overrun/underrun flag |

## Verification
Read transfers run in single-byte mode, at a mid threshold below and at the trigger level, with a short sector ended early by the last-byte mark, and at the highest threshold. These separate the occupancy trigger from the sector-end trigger and check the clamp of the level. Single and burst acknowledge streams are both used, so the one-cycle gap can be told apart from the held request. Write transfers fill the buffer in a burst and then drain it from the drive side across the threshold, which separates the full-buffer release from the reassertion level. A terminal count during a write and drive accesses at the full and empty edges show that the request stays silent and that the error flag is set.

// File: rtl/xfer_fifo_pkg.sv
// Shared constants and the direction type for the DMA byte buffer.
package xfer_fifo_pkg;
    localparam int FIFO_DEPTH = 16;
    localparam int BYTE_W     = 8;

    typedef enum logic {
        DIR_TO_DRIVE = 1'b0,
        DIR_TO_HOST  = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/xfer_fifo_store.sv
// Circular byte store with a run-time capacity limit.
// Assumes DEPTH is a power of two. cap is never above DEPTH.
// A push is refused when count >= cap. A pop is refused when empty.
// flush wins over push and pop.
module xfer_fifo_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    input  logic [CW-1:0] cap,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count_next,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count >= cap);
    assign push_ok = push & ~full & ~flush;
    assign pop_ok  = pop & ~empty & ~flush;
    assign head    = mem[rd_ptr];

    // Next occupancy, shared with the request logic.
    always_comb begin
        count_next = count;
        if (flush)
            count_next = '0;
        else if (push_ok && !pop_ok)
            count_next = count + CW'(1);
        else if (pop_ok && !push_ok)
            count_next = count - CW'(1);
    end

    // Pointers and occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
            count <= count_next;
        end
    end

    // Byte storage, written on accepted pushes.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // R12: a refused push leaves the occupancy alone.
    assert_full_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));

    // R13: occupancy never exceeds the physical depth.
    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/xfer_req_ctrl.sv
// DMA request sequencer.
// Holds the command state: active, direction, service window, sector mark.
// It derives the registered request from the next occupancy of the store.
// Assumes rd_thr >= 1 and that cap, rd_thr and wr_thr stay stable during a command.
module xfer_req_ctrl
    import xfer_fifo_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  xfer_dir_e     start_dir,
    input  logic          dma_ack,
    input  logic          dma_tc,
    input  logic          burst,
    input  logic          sec_mark,
    input  logic [CW-1:0] cnt_next,
    input  logic [CW-1:0] cap,
    input  logic [CW-1:0] rd_thr,
    input  logic [CW-1:0] wr_thr,
    output logic          req,
    output xfer_dir_e     dir
);
    logic      active_q, active_n;
    logic      svc_q, svc_n;
    logic      pend_q, pend_n;
    logic      req_q, req_n;
    xfer_dir_e dir_q, dir_n;
    logic      ack_hit, tc_hit;

    assign ack_hit = dma_ack & req_q;
    assign tc_hit  = ack_hit & dma_tc;
    assign req     = req_q;
    assign dir     = dir_q;

    // Next-state rules for the service window and the request.
    always_comb begin
        active_n = active_q;
        dir_n    = dir_q;
        svc_n    = svc_q;
        pend_n   = pend_q;
        if (start) begin
            active_n = 1'b1;
            dir_n    = start_dir;
            svc_n    = (start_dir == DIR_TO_DRIVE);
            pend_n   = 1'b0;
        end else if (!active_q || tc_hit) begin
            active_n = 1'b0;
            svc_n    = 1'b0;
            pend_n   = 1'b0;
        end else if (dir_q == DIR_TO_HOST) begin
            if (sec_mark) pend_n = 1'b1;
            if (cnt_next == '0) begin
                svc_n  = 1'b0;
                pend_n = 1'b0;
            end else if (cnt_next >= rd_thr || pend_n) begin
                svc_n = 1'b1;
            end
        end else begin
            if (cnt_next >= cap)
                svc_n = 1'b0;
            else if (cnt_next <= wr_thr)
                svc_n = 1'b1;
        end
        req_n = svc_n & ~(~burst & ack_hit);
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            dir_q    <= DIR_TO_DRIVE;
            svc_q    <= 1'b0;
            pend_q   <= 1'b0;
            req_q    <= 1'b0;
        end else begin
            active_q <= active_n;
            dir_q    <= dir_n;
            svc_q    <= svc_n;
            pend_q   <= pend_n;
            req_q    <= req_n;
        end
    end

    // R8: terminal count silences the request.
    assert_tc_silence_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit && !start) |=> !req_q);

    // R8: no request outside an active command.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !req_q);

    // R9: a single-mode acknowledge opens a one-cycle gap.
    assert_single_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && !burst && !start) |=> !req_q);

    // R10: burst read holds the request while bytes remain.
    assert_burst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_hit && burst && !dma_tc && !start && dir_q == DIR_TO_HOST
         && cnt_next != '0) |=> req_q);

    // R5: a drained read buffer drops the request.
    assert_drain_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && dir_q == DIR_TO_HOST && cnt_next == '0) |=> !req_q);
endmodule

// File: rtl/xfer_fifo_dma.sv
// Threshold-paced DMA byte buffer, top level.
// Holds the configuration and routes pushes and pops by direction.
// Derives capacity and trigger levels, and keeps the sticky drive error flag.
// Assumes the configuration is not reloaded while a command is active.
module xfer_fifo_dma
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int DW    = BYTE_W,
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thr,
    input  logic          cfg_burst,
    input  logic          cmd_start,
    input  logic          cmd_dir,
    input  logic          drv_push,
    input  logic          drv_last,
    input  logic [DW-1:0] drv_wdata,
    input  logic          drv_pop,
    output logic          drv_stall,
    input  logic          dma_ack,
    input  logic          dma_tc,
    input  logic [DW-1:0] dma_wdata,
    output logic          dma_req,
    output logic [DW-1:0] head_data,
    output logic          fifo_empty,
    output logic          fifo_full,
    output logic          xfer_err
);
    logic          en_q, burst_q, err_q;
    logic [TW-1:0] thr_q;
    logic [CW-1:0] thr_ext, cap, rd_thr, wr_thr, cnt_next;
    logic          dma_go, push, pop, to_host, sec_mark;
    logic [DW-1:0] wdata;
    xfer_dir_e     dir;

    // Configuration register, reset to buffer disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            thr_q   <= '0;
            burst_q <= 1'b0;
        end else if (cfg_wr) begin
            en_q    <= cfg_fifo_en;
            thr_q   <= cfg_thr;
            burst_q <= cfg_burst;
        end
    end

    // Capacity and trigger levels from the configuration.
    always_comb begin
        thr_ext = CW'(thr_q);
        cap     = en_q ? CW'(DEPTH) : CW'(1);
        wr_thr  = en_q ? thr_ext + CW'(1) : '0;
        if (!en_q || thr_ext == CW'(DEPTH - 1))
            rd_thr = CW'(1);
        else
            rd_thr = CW'(DEPTH - 1) - thr_ext;
    end

    // Direction-based routing of the two sides onto the store.
    assign to_host  = (dir == DIR_TO_HOST);
    assign dma_go   = dma_ack & dma_req;
    assign push     = to_host ? drv_push : dma_go;
    assign pop      = to_host ? dma_go : drv_pop;
    assign wdata    = to_host ? drv_wdata : dma_wdata;
    assign sec_mark = to_host & drv_push & drv_last & ~fifo_full;
    assign drv_stall = to_host ? fifo_full : fifo_empty;
    assign xfer_err  = err_q;

    // Sticky overrun/underrun flag for the drive side.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_start)
            err_q <= 1'b0;
        else if (to_host ? (drv_push & fifo_full) : (drv_pop & fifo_empty))
            err_q <= 1'b1;
    end

    xfer_fifo_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(cmd_start), .push(push), .pop(pop),
        .wdata(wdata), .cap(cap), .head(head_data), .count_next(cnt_next),
        .empty(fifo_empty), .full(fifo_full)
    );

    xfer_req_ctrl #(.CW(CW)) u_req (
        .clk(clk), .rst_n(rst_n), .start(cmd_start),
        .start_dir(xfer_dir_e'(cmd_dir)), .dma_ack(dma_ack), .dma_tc(dma_tc),
        .burst(burst_q), .sec_mark(sec_mark), .cnt_next(cnt_next), .cap(cap),
        .rd_thr(rd_thr), .wr_thr(wr_thr), .req(dma_req), .dir(dir)
    );

    // R12: the error flag only rises after a drive access.
    assert_err_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(drv_push || drv_pop));

    // R11: a disabled buffer is full at one byte.
    assert_single_depth_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !fifo_empty) |-> fifo_full);
endmodule

// File: tb/xfer_fifo_dma_bench.sv
module xfer_fifo_dma_bench;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 0, cfg_fifo_en = 0, cfg_burst = 0;
    logic [3:0] cfg_thr = 0;
    logic cmd_start = 0, cmd_dir = 0;
    logic drv_push = 0, drv_last = 0, drv_pop = 0;
    logic [7:0] drv_wdata = 0, dma_wdata = 0;
    logic dma_ack = 0, dma_tc = 0;
    logic drv_stall, dma_req, fifo_empty, fifo_full, xfer_err;
    logic [7:0] head_data;

    int checks = 0, errors = 0;
    bit done = 0;
    bit mode_rd = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    xfer_fifo_dma u_xfer_fifo_dma (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_fifo_en(cfg_fifo_en),
        .cfg_thr(cfg_thr), .cfg_burst(cfg_burst), .cmd_start(cmd_start),
        .cmd_dir(cmd_dir), .drv_push(drv_push), .drv_last(drv_last),
        .drv_wdata(drv_wdata), .drv_pop(drv_pop), .drv_stall(drv_stall),
        .dma_ack(dma_ack), .dma_tc(dma_tc), .dma_wdata(dma_wdata),
        .dma_req(dma_req), .head_data(head_data), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .xfer_err(xfer_err)
    );

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Monitor: compare each departing byte with the scoreboard (R13).
    always @(negedge clk) begin
        #1;
        if (rst_n && (mode_rd ? (dma_ack && dma_req) : (drv_pop && !fifo_empty))) begin
            if (exp_q.size() == 0) begin
                check("R13 unexpected byte", head_data, 0);
            end else begin
                check("R13 data order", head_data, exp_q.pop_front());
            end
        end
    end

    task automatic cfg(input bit en, input int thr, input bit b);
        cfg_wr = 1; cfg_fifo_en = en; cfg_thr = 4'(thr); cfg_burst = b;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic start(input bit rd);
        exp_q.delete();
        mode_rd = rd; cmd_start = 1; cmd_dir = rd;
        @(negedge clk); cmd_start = 0;
    endtask

    task automatic dpush(input logic [7:0] d, input bit last, input bit accept);
        drv_push = 1; drv_wdata = d; drv_last = last;
        if (accept) exp_q.push_back(d);
        @(negedge clk); drv_push = 0; drv_last = 0;
    endtask

    task automatic dpop();
        drv_pop = 1;
        @(negedge clk); drv_pop = 0;
    endtask

    task automatic dack(input logic [7:0] d, input bit tc);
        dma_ack = 1; dma_wdata = d; dma_tc = tc;
        if (!mode_rd && dma_req) exp_q.push_back(d);
        @(negedge clk); dma_ack = 0; dma_tc = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 req after reset", dma_req, 0);
        check("R1 empty after reset", fifo_empty, 1);
        check("R1 err after reset", xfer_err, 0);

        // Disabled buffer, read direction.
        start(1);
        dpush(8'hA1, 0, 1);
        check("R11 req one byte pending", dma_req, 1);
        check("R11 full at one byte", fifo_full, 1);
        check("R12 stall on full read", drv_stall, 1);
        dpush(8'hEE, 0, 0);
        check("R12 overrun sets err", xfer_err, 1);
        dack(8'h00, 0);
        check("R5 req off when drained", dma_req, 0);
        check("R1 empty after drain", fifo_empty, 1);
        check("R12 err sticky", xfer_err, 1);
        start(1);
        check("R12 start clears err", xfer_err, 0);

        // Enabled, T=12, read level 4, single mode.
        cfg(1, 11, 0);
        start(1);
        for (int i = 0; i < 3; i++) dpush(8'h10 + 8'(i), 0, 1);
        check("R3 no req below level", dma_req, 0);
        check("R2 not full at 3 bytes", fifo_full, 0);
        dpush(8'h13, 0, 1);
        check("R3 req at level", dma_req, 1);
        dack(8'h00, 0);
        check("R9 gap after ack", dma_req, 0);
        dack(8'h00, 0);
        check("R14 ack while idle ignored", dma_req, 1);
        for (int i = 0; i < 3; i++) begin
            check("R5 req held while bytes remain", dma_req, 1);
            dack(8'h00, 0);
            check("R9 gap after ack", dma_req, 0);
            @(negedge clk);
        end
        check("R5 req stays off after drain", dma_req, 0);
        check("R14 empty after exactly 4 moves", fifo_empty, 1);

        // Sector end below level.
        dpush(8'h20, 0, 1);
        check("R4 no req before sector end", dma_req, 0);
        dpush(8'h21, 1, 1);
        check("R4 req on sector end", dma_req, 1);
        dack(8'h00, 0);
        @(negedge clk);
        check("R4 req still on after gap", dma_req, 1);
        dack(8'h00, 0);
        @(negedge clk);
        check("R5 req off after sector drained", dma_req, 0);

        // Burst read.
        cfg(1, 11, 1);
        start(1);
        for (int i = 0; i < 4; i++) dpush(8'h30 + 8'(i), 0, 1);
        check("R3 burst req at level", dma_req, 1);
        dma_ack = 1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R10 burst hold read", dma_req, (i < 3) ? 1 : 0);
        end
        dma_ack = 0;
        check("R5 empty after burst", fifo_empty, 1);

        // Write direction, T=4, burst.
        cfg(1, 3, 1);
        start(0);
        check("R6 req on start", dma_req, 1);
        for (int i = 0; i < 16; i++) begin
            dma_ack = 1; dma_wdata = 8'h40 + 8'(i);
            if (dma_req) exp_q.push_back(dma_wdata);
            @(negedge clk);
            check("R6 req until full", dma_req, (i < 15) ? 1 : 0);
        end
        dma_ack = 0;
        check("R6 full after 16", fifo_full, 1);
        for (int i = 0; i < 11; i++) begin
            dpop();
            check("R7 no req above T", dma_req, 0);
        end
        dpop();
        check("R7 req at T bytes", dma_req, 1);
        check("R12 no stall with data", drv_stall, 0);
        dack(8'h77, 1);
        check("R8 req off after tc", dma_req, 0);
        for (int i = 0; i < 5; i++) begin
            dpop();
            check("R8 req silent after tc", dma_req, 0);
        end
        check("R8 drained", fifo_empty, 1);
        check("R12 stall on empty write", drv_stall, 1);
        dpop();
        check("R12 underrun sets err", xfer_err, 1);

        // Disabled write, single.
        cfg(0, 0, 0);
        start(0);
        check("R6 req on start disabled", dma_req, 1);
        dack(8'h55, 0);
        check("R11 full at one byte write", fifo_full, 1);
        @(negedge clk);
        check("R6 req off while full", dma_req, 0);
        dpop();
        check("R7 req when slot free", dma_req, 1);

        // Highest threshold clamps read level to 1.
        cfg(1, 15, 0);
        start(1);
        dpush(8'h66, 0, 1);
        check("R2 T=16 req at one byte", dma_req, 1);
        dack(8'h00, 0);
        @(negedge clk);
        check("R5 req off after drain", dma_req, 0);
        check("R13 scoreboard drained", exp_q.size(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule